// File: doc/BRIEF.md
# Sweep Conversion Sequencer with Result FIFO

This block controls a multi-channel sampling front end. It holds four fixed channel lists and walks the selected list one entry per accepted trigger. For each entry it sends a start pulse with a channel number to an external converter and waits for a done pulse. The returned result is pushed into an eight-entry FIFO, tagged with its 3-bit channel number. When the FIFO fill reaches a programmed threshold, the block pulls an active-low interrupt and the sweep ends. Entries of the list that have not been visited yet are dropped.

The trigger is either a select command on the command port (frame trigger) or a pulse on a separate external start input. In single mode a finished sweep locks the block until the FIFO is drained or the block is reconfigured. With the external start, an extra select command is then needed to arm it again. In repeat mode the next trigger throws away the old results and begins a fresh sweep at once.

Top module: `sweep_seq_ctrl`

## Requirements
- R1: A command with `cmd_op` = 3 (config write) performs the following actions: it loads the list select, the mode (`cmd_repeat`: 1 = repeat), the trigger source (`cmd_ext`: 1 = external start) and the threshold (field value + 1); it empties the FIFO; it raises `int_n`; and it makes the next conversion use the head of the list.
- R2: Each accepted trigger causes exactly one cycle of `conv_start`, with `conv_chan` set to the next list entry. The lists are: select 0 = 0,1,2,3; select 1 = 0..7; select 2 = 0,2,4,6; select 3 = 0,0,2,2,4,4,6,6. A repeated entry gets its own conversion. A `conv_done` stores `conv_data` together with that channel.
- R3: On the `conv_done` that brings the FIFO fill to the threshold, `int_n` goes low on the same edge. The next sweep starts at the head of the list, and the unvisited entries are skipped.
- R4: With the frame trigger, a command with `cmd_op` = 1 (select) is the trigger. The select command does not change the list or the position in it.
- R5: In single mode, after the threshold is reached, triggers start nothing. This lasts until reads empty the FIFO or a config write occurs.
- R6: With the external start in single mode, after the lockout is released `ext_trig` is ignored until one select command (the arm) arrives. The arm starts no conversion. The next trigger after it converts the head of the list.
- R7: In repeat mode, the first trigger after the threshold is reached does three things: it empties the FIFO, raises `int_n`, and converts the head of the list.
- R8: If the list ends before the threshold is reached, the pass ends. The next trigger begins at the head again, and its results are appended to the FIFO.
- R9: A command with `cmd_op` = 2 (read) pops one entry. The entry appears on `rd_data` and `rd_chan`, with `rd_valid` high, in the cycle after the command. A read of an empty FIFO leaves `rd_valid` low. Any pop raises `int_n`.
- R10: While a conversion is in flight, triggers and reads are ignored. A config write aborts the conversion, and a later `conv_done` stores nothing.
- R11: After reset:
  - `int_n` is high, and `conv_start` and `rd_valid` are low.
  - The block is set for list 0, single mode, frame trigger and threshold 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 none, 1 select, 2 read, 3 config write |
| cmd_seq | input | 2 | List select for config write |
| cmd_repeat | input | 1 | 1 = repeat mode |
| cmd_ext | input | 1 | 1 = external start trigger |
| cmd_thresh | input | 3 | Threshold minus one |
| ext_trig | input | 1 | External start trigger pulse |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 3 | Channel for the conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Converter result |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 12 | Read result data |
| rd_chan | output | 3 | Read result channel tag |
| int_n | output | 1 | Threshold interrupt, active low |

## Verification
The hardest state to reach is the arm wait with the external start. Getting there takes a full sweep to the threshold, a lockout, and reads that drain the FIFO to empty. Only then can the bench show that `ext_trig` is dead until a select arrives. The stimulus does exactly this chain. A second hard case is a config write landing in the middle of a conversion. The bench sends the write between start and done, and then shows through an empty read that the late done was dropped.

// File: rtl/sweep_pkg.sv
`timescale 1ns/1ps
package sweep_pkg;
  localparam int CHAN_W = 3;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_CONV, ST_LOCK, ST_ARM, ST_RDONE} state_t;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_SEL = 2'd1, OP_READ = 2'd2, OP_CFG = 2'd3} op_t;

  // list lengths: odd selects are eight long, even selects four
  function automatic logic [IDX_W:0] seq_len(input logic [1:0] sel);
    return sel[0] ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [CHAN_W-1:0] seq_chan(input logic [1:0] sel, input logic [IDX_W-1:0] idx);
    case (sel)
      2'd0:    return {1'b0, idx[1:0]};
      2'd1:    return idx;
      2'd2:    return {idx[1:0], 1'b0};
      default: return {idx[2:1], 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/sweep_seq_rom.sv
`timescale 1ns/1ps
module sweep_seq_rom
  import sweep_pkg::*;
(
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [CHAN_W-1:0] chan,
  output logic              last
);
  assign chan = seq_chan(sel, idx);
  assign last = ({1'b0, idx} == (seq_len(sel) - 1'b1));
endmodule

// File: rtl/sweep_fifo.sv
`timescale 1ns/1ps
module sweep_fifo #(
  parameter int WIDTH = 15,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             wdata,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clr && wr_ptr == PTR_W'(g)) slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; level <= '0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; level <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign rdata = slot_q[rd_ptr];

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> level < LVL_W'(DEPTH));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> level != '0);
endmodule

// File: rtl/sweep_seq_ctrl.sv
`timescale 1ns/1ps
module sweep_seq_ctrl
  import sweep_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [1:0]                  cmd_seq,
  input  logic                        cmd_repeat,
  input  logic                        cmd_ext,
  input  logic [$clog2(DEPTH)-1:0]    cmd_thresh,
  input  logic                        ext_trig,
  output logic                        conv_start,
  output logic [CHAN_W-1:0]           conv_chan,
  input  logic                        conv_done,
  input  logic [DATA_W-1:0]           conv_data,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic [CHAN_W-1:0]           rd_chan,
  output logic                        int_n
);
  localparam int THR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int ENT_W = DATA_W + CHAN_W;

  function automatic logic [LVL_W-1:0] thr_decode(input logic [THR_W-1:0] f);
    return LVL_W'(f) + LVL_W'(1);
  endfunction

  state_t            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        seq_q;
  logic              rep_q, ext_q;
  logic [LVL_W-1:0]  thr_q;

  logic [CHAN_W-1:0] rom_chan;
  logic              rom_last;
  logic [ENT_W-1:0]  fifo_rdata;
  logic [LVL_W-1:0]  fifo_level;

  // named internal events
  logic cmd_sel, cmd_rd, cmd_cfg, trig_ev, accept_ev, fifo_clr;
  logic done_ev, hit_ev, pop_ev, lock_release;

  assign cmd_sel      = cmd_valid && (cmd_op == OP_SEL);
  assign cmd_rd       = cmd_valid && (cmd_op == OP_READ);
  assign cmd_cfg      = cmd_valid && (cmd_op == OP_CFG);
  assign trig_ev      = ext_q ? ext_trig : cmd_sel;
  assign accept_ev    = (state_q == ST_IDLE || state_q == ST_RDONE) && trig_ev && !cmd_cfg;
  assign fifo_clr     = cmd_cfg || (state_q == ST_RDONE && accept_ev);
  assign done_ev      = (state_q == ST_CONV) && conv_done && !cmd_cfg;
  assign hit_ev       = done_ev && ((fifo_level + LVL_W'(1)) == thr_q);
  assign pop_ev       = cmd_rd && (state_q != ST_CONV) && (fifo_level != '0) && !fifo_clr;
  assign lock_release = (state_q == ST_LOCK) && pop_ev && (fifo_level == LVL_W'(1));

  sweep_seq_rom i_rom (
    .sel  (seq_q),
    .idx  (idx_q),
    .chan (rom_chan),
    .last (rom_last)
  );

  sweep_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (done_ev),
    .pop   (pop_ev),
    .wdata ({conv_chan, conv_data}),
    .rdata (fifo_rdata),
    .level (fifo_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      seq_q      <= '0;
      rep_q      <= 1'b0;
      ext_q      <= 1'b0;
      thr_q      <= LVL_W'(DEPTH);
      conv_start <= 1'b0;
      conv_chan  <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_chan    <= '0;
      int_n      <= 1'b1;
    end else begin
      conv_start <= 1'b0;
      rd_valid   <= pop_ev;
      if (pop_ev) begin
        rd_data <= fifo_rdata[DATA_W-1:0];
        rd_chan <= fifo_rdata[DATA_W +: CHAN_W];
        int_n   <= 1'b1;
      end
      if (cmd_cfg) begin
        seq_q   <= cmd_seq;
        rep_q   <= cmd_repeat;
        ext_q   <= cmd_ext;
        thr_q   <= thr_decode(cmd_thresh);
        idx_q   <= '0;
        int_n   <= 1'b1;
        state_q <= (state_q == ST_LOCK && cmd_ext) ? ST_ARM : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE, ST_RDONE: begin
            if (accept_ev) begin
              state_q    <= ST_CONV;
              conv_start <= 1'b1;
              conv_chan  <= rom_chan;
              int_n      <= 1'b1;
            end
          end
          ST_CONV: begin
            if (hit_ev) begin
              state_q <= rep_q ? ST_RDONE : ST_LOCK;
              idx_q   <= '0;
              int_n   <= 1'b0;
            end else if (done_ev) begin
              state_q <= ST_IDLE;
              idx_q   <= rom_last ? '0 : idx_q + 1'b1;
            end
          end
          ST_LOCK: if (lock_release) state_q <= ext_q ? ST_ARM : ST_IDLE;
          ST_ARM:  if (cmd_sel) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R10
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |=> !conv_start);
  // R5
  lock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |=> !conv_start);
  // R3
  int_at_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (fifo_level == thr_q));
  // R1
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cfg |=> (int_n && fifo_level == '0));
endmodule

// File: tb/test_sweep_seq_ctrl.sv
`timescale 1ns/1ps
module test_sweep_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [1:0]  cmd_seq = 0;
  logic        cmd_repeat = 0, cmd_ext = 0;
  logic [2:0]  cmd_thresh = 0;
  logic        ext_trig = 0;
  logic        conv_start, conv_done = 0;
  logic [2:0]  conv_chan;
  logic [11:0] conv_data = 0;
  logic        rd_valid;
  logic [11:0] rd_data;
  logic [2:0]  rd_chan;
  logic        int_n;

  int n_chk = 0, n_fail = 0;
  bit b_ext = 0, finished = 0;

  sweep_seq_ctrl i_sweep_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_seq(cmd_seq), .cmd_repeat(cmd_repeat), .cmd_ext(cmd_ext),
    .cmd_thresh(cmd_thresh), .ext_trig(ext_trig), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_chan(rd_chan), .int_n(int_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int seq, input bit rep, input bit ext, input int thr);
    cmd_valid = 1; cmd_op = 2'd3; cmd_seq = 2'(seq); cmd_repeat = rep;
    cmd_ext = ext; cmd_thresh = 3'(thr);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    b_ext = ext;
  endtask

  task automatic sel();
    cmd_valid = 1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic trig(input bit exp_start, input int exp_chan, input string req);
    if (b_ext) begin
      ext_trig = 1; @(negedge clk); ext_trig = 0;
    end else sel();
    chk(req, conv_start, exp_start);
    if (exp_start) chk(req, conv_chan, exp_chan);
  endtask

  task automatic done(input int d);
    conv_done = 1; conv_data = 12'(d);
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic conv(input int exp_chan, input int d, input string req);
    trig(1, exp_chan, req);
    done(d);
  endtask

  task automatic rd(input bit exp_v, input int exp_d, input int exp_c, input string req);
    cmd_valid = 1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    chk(req, rd_valid, exp_v);
    if (exp_v) begin
      chk(req, rd_data, exp_d);
      chk(req, rd_chan, exp_c);
    end
  endtask

  // R11 reset state and defaults
  task automatic t_reset();
    chk("R11 int_n", int_n, 1);
    chk("R11 conv_start", conv_start, 0);
    chk("R11 rd_valid", rd_valid, 0);
    conv(0, 'h001, "R11 default list");
    conv(1, 'h002, "R11 default list");
    chk("R11 no int before 8", int_n, 1);
  endtask

  // R2 R3 R4 R5 R9 single mode, frame trigger, duplicate entries
  task automatic t_single();
    cfg(3, 0, 0, 4);
    chk("R1 int released", int_n, 1);
    conv(0, 'h10, "R2 dup list");
    conv(0, 'h11, "R2 dup list");
    conv(2, 'h12, "R4 select is dummy");
    conv(2, 'h13, "R2 dup list");
    chk("R3 below threshold", int_n, 1);
    conv(4, 'h14, "R2 dup list");
    chk("R3 at threshold", int_n, 0);
    trig(0, 0, "R5 locked");
    trig(0, 0, "R5 locked");
    rd(1, 'h10, 0, "R9 pop");
    chk("R9 int on first read", int_n, 1);
    rd(1, 'h11, 0, "R9 pop");
    rd(1, 'h12, 2, "R9 pop");
    rd(1, 'h13, 2, "R9 pop");
    trig(0, 0, "R5 still locked");
    rd(1, 'h14, 4, "R9 pop");
    rd(0, 0, 0, "R9 empty");
    conv(0, 'h20, "R3 skipped tail, head");
  endtask

  // R7 repeat mode
  task automatic t_repeat();
    cfg(2, 1, 0, 1);
    conv(0, 'h30, "R7 list 2");
    conv(2, 'h31, "R7 list 2");
    chk("R7 int at threshold", int_n, 0);
    trig(1, 0, "R7 restart head");
    chk("R7 int released", int_n, 1);
    done('h32);
    rd(1, 'h32, 0, "R7 old cleared");
    rd(0, 0, 0, "R7 one entry");
  endtask

  // R8 wrap and R1 config write in lockout
  task automatic t_wrap();
    cfg(0, 0, 0, 7);
    for (int i = 0; i < 8; i++) begin
      conv(i % 4, 'h40 + i, "R8 wrap to head");
      if (i == 6) chk("R8 no int at 7", int_n, 1);
    end
    chk("R8 int at 8", int_n, 0);
    rd(1, 'h40, 0, "R8 appended");
    cfg(0, 0, 0, 7);
    chk("R1 int high", int_n, 1);
    rd(0, 0, 0, "R1 fifo emptied");
    conv(0, 'h48, "R1 head after cfg");
  endtask

  // R6 external start with arm
  task automatic t_ext();
    cfg(1, 0, 1, 1);
    conv(0, 'h50, "R6 ext list 1");
    conv(1, 'h51, "R6 ext list 1");
    chk("R6 int", int_n, 0);
    trig(0, 0, "R5 ext locked");
    rd(1, 'h50, 0, "R6 drain");
    rd(1, 'h51, 1, "R6 drain");
    trig(0, 0, "R6 needs arm");
    sel();
    chk("R6 arm starts nothing", conv_start, 0);
    conv(0, 'h52, "R6 armed head");
  endtask

  // R10 busy behaviour and abort
  task automatic t_busy();
    cfg(0, 0, 0, 7);
    trig(1, 0, "R10 first");
    sel();
    chk("R10 trig ignored in conv", conv_start, 0);
    done('h60);
    trig(1, 1, "R10 next entry");
    rd(0, 0, 0, "R10 read ignored in conv");
    done('h61);
    trig(1, 2, "R10 third");
    cfg(0, 0, 0, 7);
    done('h62);
    rd(0, 0, 0, "R10 late done dropped");
    conv(0, 'h63, "R10 head after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_repeat();
    t_wrap();
    t_ext();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule